// File: doc/BRIEF.md
# Maskable Calendar Alarm Comparator with Interrupt / Clock Output Pin

This block watches the running calendar (seconds, minutes, hour, date, month, weekday) and compares it against two alarm register sets. Every alarm byte carries a match-enable flag in bit 7. Only fields whose flag is set take part in the comparison, so a single alarm can fire once a year, every weekday, every hour or every minute. The first alarm set covers all six calendar fields. The second covers minutes, hour and one shared day byte, in which bit 6 chooses between date and weekday. A match raises a sticky status flag for that alarm.

One output pin is shared by two uses. In interrupt mode it is pulled low by the first alarm's flag, and only when that alarm's pin enable is on. In clock mode it carries a square wave divided from an oscillator step strobe. The flags are cleared by explicit strobes, or, when auto-clear is on, by a status read strobe. The register bus that holds the alarm and control bytes sits outside this block, which sees them as plain inputs.

Top module: `alarm_pin_unit`

## Requirements
- R1: After reset both alarm flags are 0 and the oscillator divider is 0, so in clock mode with select 00 the pin reads 0.
- R2: When every enabled field of alarm 1 equals the current time in bits 6:0, flag_al1 rises at the second rising edge after tick_1hz is sampled high.
- R3: A field whose bit 7 is 0 is ignored. With only the seconds byte enabled, alarm 1 fires even though the other alarm bytes differ from the time.
- R4: An alarm with no enabled field never sets its flag.
- R5: Alarm 2 compares minutes, hour and the day byte al2_day. When al2_day[6]=1, bits 5:0 are compared with now_wday[5:0]. When al2_day[6]=0, they are compared with now_date[5:0]. A match sets flag_al2.
- R6: A flag stays set until clr_al1 or clr_al2 is pulsed. A set and a clear in the same cycle leave the flag set.
- R7: When auto_clr=1, a stat_rd pulse clears both flags. When auto_clr=0, stat_rd has no effect on the flags.
- R8: When irq_mode=1, pin_n is 0 exactly while flag_al1=1 and al1_pin_en=1. flag_al2 never pulls the pin low.
- R9: When irq_mode=0, pin_n follows a 16-bit counter that increments on each osc_tick. fsel 00 selects bit 0 (32768 Hz for a 65536 Hz strobe), 01 selects bit 2 (8192 Hz), 10 selects bit 3 (4096 Hz) and 11 selects bit 15 (1 Hz).
- R10: Matches are only evaluated on the cycle after a tick. A time that matches with no tick does not set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| osc_tick | input | 1 | Divider step strobe, twice the base oscillator rate |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hour, BCD with format bit 6 |
| now_date | input | 7 | Current date, BCD |
| now_month | input | 7 | Current month, BCD |
| now_wday | input | 7 | Current weekday |
| al1_sec | input | 8 | Alarm 1 seconds, bit 7 enable |
| al1_min | input | 8 | Alarm 1 minutes, bit 7 enable |
| al1_hour | input | 8 | Alarm 1 hour, bit 7 enable |
| al1_date | input | 8 | Alarm 1 date, bit 7 enable |
| al1_month | input | 8 | Alarm 1 month, bit 7 enable |
| al1_wday | input | 8 | Alarm 1 weekday, bit 7 enable |
| al2_min | input | 8 | Alarm 2 minutes, bit 7 enable |
| al2_hour | input | 8 | Alarm 2 hour, bit 7 enable |
| al2_day | input | 8 | Alarm 2 day, bit 7 enable, bit 6 weekday select |
| irq_mode | input | 1 | 1 selects interrupt mode, 0 selects clock mode |
| al1_pin_en | input | 1 | Lets alarm 1 drive the pin |
| fsel | input | 2 | Clock output select |
| auto_clr | input | 1 | Lets a status read clear the flags |
| clr_al1 | input | 1 | Clear strobe for alarm 1 flag |
| clr_al2 | input | 1 | Clear strobe for alarm 2 flag |
| stat_rd | input | 1 | Status read strobe |
| flag_al1 | output | 1 | Alarm 1 status flag |
| flag_al2 | output | 1 | Alarm 2 status flag |
| pin_n | output | 1 | Pin level, 1 means released |

## Verification
The bench targets a set and a clear that land in the same cycle. A design with the wrong priority would drop a fresh alarm there. It also targets the all-fields-disabled alarm, where a matcher built as "no mismatch" would fire every second. The weekday/date selector of alarm 2 is driven both ways with values that match only one of the two fields, which exposes a swapped or ignored selector. The bench also checks that a matching time with no tick leaves the flags clear, that a status read with auto-clear off has no effect, that alarm 2 never pulls the pin low, and that each clock-select setting taps the correct divider bit, the 1 Hz tap included.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int VALW = 7;
  localparam int REGW = 8;
  localparam int NF1  = 6;
  localparam int NF2  = 3;
  typedef logic [VALW-1:0] tval_t;
  typedef logic [REGW-1:0] areg_t;
  typedef enum logic [1:0] {
    FO_FAST = 2'b00,
    FO_Q    = 2'b01,
    FO_E    = 2'b10,
    FO_SLOW = 2'b11
  } fo_sel_e;
endpackage

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
#(
  parameter int NF = 6
) (
  input  logic [NF-1:0][VALW-1:0] cur_i,
  input  logic [NF-1:0][REGW-1:0] alm_i,
  output logic                    hit_o
);
  logic [NF-1:0] en;
  logic [NF-1:0] ok;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign en[g] = alm_i[g][REGW-1];
    assign ok[g] = !en[g] || (cur_i[g] == alm_i[g][VALW-1:0]);
  end

  assign hit_o = (|en) && (&ok);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eval_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)            flag_d = 1'b0;
    if (eval_i && hit_i)  flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R2 / R10: a flag only rises right after an evaluation with a hit
  a_r10_rise_needs_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(eval_i && hit_i));
  // R6: a clear without a coincident set empties the flag
  a_r6_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(eval_i && hit_i)) |=> !flag_q);
  // R6: a set always wins
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && hit_i) |=> flag_q);
endmodule

// File: rtl/osc_div.sv
module osc_div
  import alm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [1:0] sel_i,
  output logic       wave_o
);
  localparam int TAP_FAST = 0;
  localparam int TAP_Q    = 2;
  localparam int TAP_E    = 3;
  localparam int TAP_SLOW = DIV_W - 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    unique case (fo_sel_e'(sel_i))
      FO_FAST: wave_o = cnt_q[TAP_FAST];
      FO_Q:    wave_o = cnt_q[TAP_Q];
      FO_E:    wave_o = cnt_q[TAP_E];
      default: wave_o = cnt_q[TAP_SLOW];
    endcase
  end

  // R9: divider advances by one per step and holds otherwise
  a_r9_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> cnt_q == DIV_W'($past(cnt_q) + 1'b1));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/alarm_pin_unit.sv
module alarm_pin_unit
  import alm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       osc_tick,
  input  logic [6:0] now_sec,
  input  logic [6:0] now_min,
  input  logic [6:0] now_hour,
  input  logic [6:0] now_date,
  input  logic [6:0] now_month,
  input  logic [6:0] now_wday,
  input  logic [7:0] al1_sec,
  input  logic [7:0] al1_min,
  input  logic [7:0] al1_hour,
  input  logic [7:0] al1_date,
  input  logic [7:0] al1_month,
  input  logic [7:0] al1_wday,
  input  logic [7:0] al2_min,
  input  logic [7:0] al2_hour,
  input  logic [7:0] al2_day,
  input  logic       irq_mode,
  input  logic       al1_pin_en,
  input  logic [1:0] fsel,
  input  logic       auto_clr,
  input  logic       clr_al1,
  input  logic       clr_al2,
  input  logic       stat_rd,
  output logic       flag_al1,
  output logic       flag_al2,
  output logic       pin_n
);
  logic tick_q;
  logic hit1, hit2, wave, rd_clr;
  logic [NF1-1:0][VALW-1:0] cur1;
  logic [NF1-1:0][REGW-1:0] alm1;
  logic [NF2-1:0][VALW-1:0] cur2;
  logic [NF2-1:0][REGW-1:0] alm2;
  tval_t day2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_1hz;
  end

  assign cur1 = {now_wday, now_month, now_date, now_hour, now_min, now_sec};
  assign alm1 = {al1_wday, al1_month, al1_date, al1_hour, al1_min, al1_sec};
  assign day2 = {al2_day[6], (al2_day[6] ? now_wday[5:0] : now_date[5:0])};
  assign cur2 = {day2, now_hour, now_min};
  assign alm2 = {al2_day, al2_hour, al2_min};

  alm_match #(.NF(NF1)) u_m1 (.cur_i(cur1), .alm_i(alm1), .hit_o(hit1));
  alm_match #(.NF(NF2)) u_m2 (.cur_i(cur2), .alm_i(alm2), .hit_o(hit2));

  assign rd_clr = stat_rd && auto_clr;

  alm_flag u_f1 (.clk_i(clk), .rst_ni(rst_n), .eval_i(tick_q), .hit_i(hit1),
                 .clr_i(clr_al1 || rd_clr), .flag_o(flag_al1));
  alm_flag u_f2 (.clk_i(clk), .rst_ni(rst_n), .eval_i(tick_q), .hit_i(hit2),
                 .clr_i(clr_al2 || rd_clr), .flag_o(flag_al2));

  osc_div #(.DIV_W(DIV_W)) u_div (.clk_i(clk), .rst_ni(rst_n), .step_i(osc_tick),
                                  .sel_i(fsel), .wave_o(wave));

  assign pin_n = irq_mode ? !(flag_al1 && al1_pin_en) : wave;

  // R8: alarm 2 alone never pulls the pin low
  a_r8_a2_no_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && !flag_al1) |-> pin_n);
  // R7: an auto-clearing read with no evaluation leaves both flags clear
  a_r7_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && auto_clr && !tick_q) |=> (!flag_al1 && !flag_al2));
  // R4: an alarm with no enabled field cannot raise its flag
  a_r4_empty_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && !(al1_sec[7] | al1_min[7] | al1_hour[7] | al1_date[7] |
                 al1_month[7] | al1_wday[7]) && !flag_al1) |=> !flag_al1);
endmodule

// File: tb/tb_alarm_pin_unit.sv
`timescale 1ns/1ps
module tb_alarm_pin_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 0, osc_tick = 0;
  logic [6:0] now_sec = 0, now_min = 0, now_hour = 0, now_date = 0, now_month = 0, now_wday = 0;
  logic [7:0] al1_sec = 0, al1_min = 0, al1_hour = 0, al1_date = 0, al1_month = 0, al1_wday = 0;
  logic [7:0] al2_min = 0, al2_hour = 0, al2_day = 0;
  logic irq_mode = 0, al1_pin_en = 0, auto_clr = 0, clr_al1 = 0, clr_al2 = 0, stat_rd = 0;
  logic [1:0] fsel = 0;
  logic flag_al1, flag_al2, pin_n;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference model state
  int m_div;
  bit m_a1, m_a2, m_tick;

  always #4 clk = ~clk;

  alarm_pin_unit dut (.*);

  function automatic bit fmatch(input logic [6:0] c, input logic [7:0] a, inout int nen);
    if (a[7]) begin
      nen++;
      return c == a[6:0];
    end
    return 1'b1;
  endfunction

  function automatic bit ref_hit1();
    int n = 0;
    bit ok = 1;
    ok &= fmatch(now_sec, al1_sec, n);
    ok &= fmatch(now_min, al1_min, n);
    ok &= fmatch(now_hour, al1_hour, n);
    ok &= fmatch(now_date, al1_date, n);
    ok &= fmatch(now_month, al1_month, n);
    ok &= fmatch(now_wday, al1_wday, n);
    return ok && (n > 0);
  endfunction

  function automatic bit ref_hit2();
    int n = 0;
    bit ok = 1;
    int dv;
    ok &= fmatch(now_min, al2_min, n);
    ok &= fmatch(now_hour, al2_hour, n);
    if (al2_day[7]) begin
      n++;
      dv = al2_day[6] ? int'(now_wday[5:0]) : int'(now_date[5:0]);
      ok &= (dv == int'(al2_day[5:0]));
    end
    return ok && (n > 0);
  endfunction

  function automatic bit ref_pin();
    int tap;
    if (irq_mode) return !(m_a1 && al1_pin_en);
    case (fsel)
      2'b00: tap = 0;
      2'b01: tap = 2;
      2'b10: tap = 3;
      default: tap = 15;
    endcase
    return ((m_div >> tap) & 1) != 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_a1 = 0; m_a2 = 0; m_tick = 0;
    end else begin
      bit h1, h2;
      h1 = m_tick && ref_hit1();
      h2 = m_tick && ref_hit2();
      if (clr_al1 || (stat_rd && auto_clr)) m_a1 = 0;
      if (clr_al2 || (stat_rd && auto_clr)) m_a2 = 0;
      if (h1) m_a1 = 1;
      if (h2) m_a2 = 1;
      m_tick = tick_1hz;
      if (osc_tick) m_div = (m_div + 1) % 65536;
    end
  end

  task automatic chk(input string r, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", r, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({cur_req, " flag_al1"}, flag_al1, m_a1);
      chk({cur_req, " flag_al2"}, flag_al2, m_a2);
      chk({cur_req, " pin_n"}, pin_n, ref_pin());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) tick_1hz = 1;
    @(negedge clk) tick_1hz = 0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [6:0] s, mi, h, d, mo, w);
    now_sec = s; now_min = mi; now_hour = h; now_date = d; now_month = mo; now_wday = w;
  endtask

  task automatic clear_all();
    @(negedge clk) begin clr_al1 = 1; clr_al2 = 1; end
    @(negedge clk) begin clr_al1 = 0; clr_al2 = 0; end
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 flag_al1 reset", flag_al1, 0);
    chk("R1 flag_al2 reset", flag_al2, 0);
    chk("R1 pin reset", pin_n, 0);

    // R2: full alarm 1 match, interrupt mode
    cur_req = "R2";
    irq_mode = 1; al1_pin_en = 1;
    set_time(7'h56, 7'h34, 7'h12, 7'h21, 7'h03, 7'h02);
    al1_sec = 8'hD6; al1_min = 8'hB4; al1_hour = 8'h92;
    al1_date = 8'hA1; al1_month = 8'h83; al1_wday = 8'h82;
    tick();
    chk("R2 alarm1 full match", flag_al1, 1);
    chk("R8 pin low on alarm1", pin_n, 0);
    al1_pin_en = 0;
    @(negedge clk);
    chk("R8 pin released when pin enable off", pin_n, 1);
    al1_pin_en = 1;

    // R6: clear, then set-and-clear in one cycle
    cur_req = "R6";
    @(negedge clk) clr_al1 = 1;
    @(negedge clk) clr_al1 = 0;
    chk("R6 cleared", flag_al1, 0);
    @(negedge clk) tick_1hz = 1;
    @(negedge clk) begin tick_1hz = 0; clr_al1 = 1; end
    @(negedge clk) clr_al1 = 0;
    chk("R6 set wins over clear", flag_al1, 1);
    cyc(3);
    chk("R6 flag sticky", flag_al1, 1);
    clear_all();

    // R2 mismatch in one enabled field
    cur_req = "R2";
    now_month = 7'h04;
    tick();
    chk("R2 month mismatch no fire", flag_al1, 0);

    // R3: only seconds enabled
    cur_req = "R3";
    al1_min = 8'h11; al1_hour = 8'h05; al1_date = 8'h09; al1_month = 8'h07; al1_wday = 8'h06;
    tick();
    chk("R3 wildcards ignored", flag_al1, 1);
    clear_all();

    // R4: no enabled fields
    cur_req = "R4";
    al1_sec = 8'h56;
    set_time(7'h56, 7'h11, 7'h05, 7'h09, 7'h07, 7'h06);
    tick();
    chk("R4 empty alarm1 no fire", flag_al1, 0);
    tick();
    chk("R4 empty alarm2 no fire", flag_al2, 0);

    // R10: matching time without tick
    cur_req = "R10";
    al1_sec = 8'hD6;
    cyc(10);
    chk("R10 no tick no fire", flag_al1, 0);
    al1_sec = 8'h00;

    // R5: alarm 2 weekday select
    cur_req = "R5";
    set_time(7'h00, 7'h30, 7'h08, 7'h15, 7'h01, 7'h03);
    al2_min = 8'hB0; al2_hour = 8'h88; al2_day = 8'hC3;
    tick();
    chk("R5 weekday select match", flag_al2, 1);
    chk("R8 alarm2 leaves pin released", pin_n, 1);
    clear_all();
    al2_day = 8'hC5;
    tick();
    chk("R5 weekday mismatch", flag_al2, 0);
    al2_day = 8'h95;
    tick();
    chk("R5 date select match", flag_al2, 1);
    clear_all();
    al2_day = 8'h83;
    tick();
    chk("R5 date select ignores weekday", flag_al2, 0);

    // R7: auto clear on status read
    cur_req = "R7";
    al2_day = 8'h95;
    al1_sec = 8'h80;
    tick();
    chk("R7 both set", flag_al1 & flag_al2, 1);
    @(negedge clk) stat_rd = 1;
    @(negedge clk) stat_rd = 0;
    chk("R7 read without auto clear keeps a1", flag_al1, 1);
    chk("R7 read without auto clear keeps a2", flag_al2, 1);
    auto_clr = 1;
    @(negedge clk) stat_rd = 1;
    @(negedge clk) stat_rd = 0;
    chk("R7 auto clear a1", flag_al1, 0);
    chk("R7 auto clear a2", flag_al2, 0);
    chk("R8 pin released after auto clear", pin_n, 1);
    auto_clr = 0;
    al1_sec = 8'h00; al2_day = 8'h00; al2_min = 8'h00; al2_hour = 8'h00;

    // R9: clock output, all selects
    cur_req = "R9";
    irq_mode = 0;
    osc_tick = 1;
    for (int s = 0; s < 3; s++) begin
      fsel = 2'(s);
      cyc(40);
    end
    fsel = 2'b11;
    osc_tick = 0;
    cyc(5);
    chk("R9 divider holds without step", pin_n, ref_pin());
    osc_tick = 1;
    cyc(66000);
    osc_tick = 0;
    @(negedge clk);
    chk("R9 1 Hz tap", pin_n, ref_pin());

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule